// File: doc/BRIEF.md
# Stacked Register Frame Renamer

This block translates the logical general-register number of an instruction into a physical register number. Logical numbers 0 to 31 name a fixed set of static registers that every procedure shares. Logical numbers from 32 upward name the current procedure's frame. That frame lives in a circular pool of 96 physical stacked registers, and a base pointer marks where the frame starts in the pool.

A procedure call opens a new frame just above the caller's frame. The caller's registers stay in the pool but can no longer be reached. A return moves the base back, so the caller sees its own registers again. The block counts how many pool registers hold live data. When a new frame would not fit, it asks an external engine to spill the oldest registers to memory, one at a time. When a returning caller's frame is no longer fully in the pool, it asks for the missing registers to be filled back, one at a time. A history of 16 saved frame sizes limits how deep calls may nest.

Frame commands arrive on a valid/ready channel. The requester raises `cmd_valid_i` and must hold it, together with `cmd_call_i` and `cmd_size_i`, until a cycle in which `cmd_ready_o` is high. That cycle is the acknowledge, and the new frame is in force from the next cycle. `cmd_ready_o` is only meaningful while `cmd_valid_i` is high, and it stays low while spill or fill traffic is still needed. Spill and fill requests are valid/ready outputs. The transfer engine may stall them for any number of cycles by holding its ready low. A request advances only in a cycle where both valid and ready are high. The lookup port is purely combinational.

Top module: `frame_renamer`

## Requirements
- R1: A logical number below 32 maps to the physical register with the same number, and `lk_oob_o` stays 0.
- R2: A logical number L of 32 or more whose offset L−32 lies inside the current frame maps to 32 + ((base + L − 32) mod 96). After reset, base and frame size are both 0.
- R3: A logical number L at or beyond 32 plus the current frame size sets `lk_oob_o` to 1.
- R4: An acknowledged call (`cmd_call_i`=1) with size N ≤ 96 advances the base by the caller's frame size, modulo 96, and makes the frame size N. Logical 32 then names the first register of the new frame.
- R5: An acknowledged return (`cmd_call_i`=0) moves the base back by the saved caller size and restores that size. The mapping is then the same as before the matching call.
- R6: If live registers plus N would exceed 96, a call first issues spill requests, oldest first, one per handshake. Each request carries index 32 + ((base + size − live) mod 96). The call is acknowledged only once live + N ≤ 96.
- R7: On a return whose caller registers are not all resident, the dying frame is released first. Fill requests are then issued from the highest missing register downward, each with index 32 + ((base − resident − 1) mod 96). The return is acknowledged only after the last fill handshake.
- R8: A call made while 16 sizes are already saved, or with N > 96, is acknowledged at once with `cmd_err_o`=1 and leaves the mapping unchanged.
- R9: A return with no saved size is acknowledged at once with `cmd_err_o`=1 and leaves the mapping unchanged.
- R10: Spill and fill requests are never valid in the same cycle. Neither of them is valid in a cycle where a command is acknowledged.
- R11: During the acknowledge cycle, the lookup port still shows the old frame. The new frame takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_lreg_i | input | 7 | Logical register number to translate |
| lk_preg_o | output | 7 | Physical register number |
| lk_oob_o | output | 1 | Logical number lies outside the current frame |
| cmd_valid_i | input | 1 | Frame command present |
| cmd_ready_o | output | 1 | Frame command acknowledged this cycle |
| cmd_call_i | input | 1 | 1 = call, 0 = return |
| cmd_size_i | input | 7 | Size of the new frame for a call |
| cmd_err_o | output | 1 | Acknowledged command was refused (history full or empty, or size too large) |
| spill_valid_o | output | 1 | Spill request present |
| spill_ready_i | input | 1 | Transfer engine takes the spill request |
| spill_preg_o | output | 7 | Physical register to save to memory |
| fill_valid_o | output | 1 | Fill request present |
| fill_ready_i | input | 1 | Transfer engine confirms the fill |
| fill_preg_o | output | 7 | Physical register to restore from memory |

## Verification
The lookup port and a frame-changing acknowledge can fall in the same cycle. The bench holds logical 32 on the lookup port for the whole time a command is pending. In the acknowledge cycle it checks that the old base is still shown, or that the register reads as out of frame after a dying frame was released for a fill. It then checks the new mapping one cycle later. Spill and fill traffic is run both with ready held high and with ready stalled on alternate cycles. Every transfer is matched in order against the indices a reference model predicts, and the pending command must not be acknowledged while any of that traffic remains.

// File: rtl/frren_pkg.sv
package frren_pkg;
  localparam int unsigned DEF_STATIC = 32;
  localparam int unsigned DEF_POOL   = 96;
  localparam int unsigned DEF_HIST   = 16;

  typedef enum logic {
    OP_RETURN = 1'b0,
    OP_CALL   = 1'b1
  } frame_op_e;

  // Reduce a sum in [0, 3*pool) into [0, pool).
  function automatic int unsigned pool_wrap(input int unsigned x, input int unsigned pool);
    if (x >= 2 * pool) return x - 2 * pool;
    else if (x >= pool) return x - pool;
    else return x;
  endfunction
endpackage

// File: rtl/frren_hist.sv
module frren_hist #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] top_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] fill_cnt;

  assign full_o  = (fill_cnt == CW'(DEPTH));
  assign empty_o = (fill_cnt == '0);
  assign top_o   = empty_o ? '0 : slots[AW'(fill_cnt - 1'b1)];

  always_ff @(posedge clk) begin
    if (push_i) slots[AW'(fill_cnt)] <= data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fill_cnt <= '0;
    else if (push_i) fill_cnt <= fill_cnt + 1'b1;
    else if (pop_i) fill_cnt <= fill_cnt - 1'b1;
  end

  // R8: a refused call never reaches the history
  a_r8_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !full_o);
  // R9: a refused return never pops
  a_r9_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop_i |-> !empty_o);
  a_r8_single_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(push_i && pop_i));
endmodule

// File: rtl/frren_map.sv
module frren_map #(
  parameter int unsigned STATIC = 32,
  parameter int unsigned POOL   = 96,
  parameter int unsigned LREG_W = 7,
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned SIZE_W = 7
) (
  input  logic [LREG_W-1:0] lreg_i,
  input  logic [PTR_W-1:0]  base_i,
  input  logic [SIZE_W-1:0] size_i,
  output logic [LREG_W-1:0] preg_o,
  output logic              oob_o
);
  int unsigned offset;
  int unsigned slot;

  always_comb begin
    offset = 0;
    slot   = 0;
    if (32'(lreg_i) < STATIC) begin
      preg_o = lreg_i;
      oob_o  = 1'b0;
    end else begin
      offset = 32'(lreg_i) - STATIC;
      slot   = frren_pkg::pool_wrap(32'(base_i) + offset, POOL);
      oob_o  = (offset >= 32'(size_i));
      preg_o = LREG_W'(STATIC + slot);
    end
  end
endmodule

// File: rtl/frren_ctrl.sv
module frren_ctrl #(
  parameter int unsigned STATIC = 32,
  parameter int unsigned POOL   = 96,
  parameter int unsigned LREG_W = 7,
  parameter int unsigned PTR_W  = 7,
  parameter int unsigned SIZE_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid_i,
  input  logic              cmd_call_i,
  input  logic [SIZE_W-1:0] cmd_size_i,
  output logic              cmd_ready_o,
  output logic              cmd_err_o,
  output logic              spill_valid_o,
  input  logic              spill_ready_i,
  output logic [LREG_W-1:0] spill_preg_o,
  output logic              fill_valid_o,
  input  logic              fill_ready_i,
  output logic [LREG_W-1:0] fill_preg_o,
  input  logic [SIZE_W-1:0] hist_top_i,
  input  logic              hist_full_i,
  input  logic              hist_empty_i,
  output logic              hist_push_o,
  output logic              hist_pop_o,
  output logic [SIZE_W-1:0] hist_data_o,
  output logic [PTR_W-1:0]  base_o,
  output logic [SIZE_W-1:0] size_o
);
  import frren_pkg::*;

  logic [PTR_W-1:0]  base_q;
  logic [SIZE_W-1:0] size_q;
  logic [SIZE_W-1:0] live_q;   // stacked registers currently holding data

  frame_op_e   op;
  logic        is_call, is_ret;
  logic        call_bad, call_fits, ret_bad, ret_fits;
  logic        ack_ok, release_dying;
  logic [SIZE_W-1:0] resident;

  assign op      = frame_op_e'(cmd_call_i);
  assign is_call = cmd_valid_i && (op == OP_CALL);
  assign is_ret  = cmd_valid_i && (op == OP_RETURN);

  assign call_bad  = hist_full_i || (32'(cmd_size_i) > POOL);
  assign call_fits = (32'(live_q) + 32'(cmd_size_i)) <= POOL;
  assign ret_bad   = hist_empty_i;
  assign resident  = live_q - size_q;
  assign ret_fits  = resident >= hist_top_i;

  assign cmd_ready_o = (is_call && (call_bad || call_fits)) ||
                       (is_ret && (ret_bad || ret_fits));
  assign cmd_err_o   = (is_call && call_bad) || (is_ret && ret_bad);
  assign ack_ok      = cmd_ready_o && !cmd_err_o;

  assign spill_valid_o = is_call && !call_bad && !call_fits;
  assign release_dying = is_ret && !ret_bad && !ret_fits && (size_q != '0);
  assign fill_valid_o  = is_ret && !ret_bad && !ret_fits && (size_q == '0);

  assign spill_preg_o = LREG_W'(STATIC +
    pool_wrap(32'(base_q) + 32'(size_q) + POOL - 32'(live_q), POOL));
  assign fill_preg_o  = LREG_W'(STATIC +
    pool_wrap(32'(base_q) + 2 * POOL - 32'(live_q) - 1, POOL));

  assign hist_push_o = ack_ok && (op == OP_CALL);
  assign hist_pop_o  = ack_ok && (op == OP_RETURN);
  assign hist_data_o = size_q;
  assign base_o      = base_q;
  assign size_o      = size_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      size_q <= '0;
      live_q <= '0;
    end else if (hist_push_o) begin
      base_q <= PTR_W'(pool_wrap(32'(base_q) + 32'(size_q), POOL));
      size_q <= cmd_size_i;
      live_q <= live_q + cmd_size_i;
    end else if (hist_pop_o) begin
      base_q <= PTR_W'(pool_wrap(32'(base_q) + POOL - 32'(hist_top_i), POOL));
      size_q <= hist_top_i;
      live_q <= live_q - size_q;
    end else if (spill_valid_o && spill_ready_i) begin
      live_q <= live_q - 1'b1;
    end else if (release_dying) begin
      live_q <= live_q - size_q;
      size_q <= '0;
    end else if (fill_valid_o && fill_ready_i) begin
      live_q <= live_q + 1'b1;
    end
  end

  // R6: the live count never passes the pool size
  a_r6_live_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    32'(live_q) <= POOL);
  // R6: every spill handshake frees exactly one register
  a_r6_spill_frees_one: assert property (@(posedge clk) disable iff (!rst_n)
    (spill_valid_o && spill_ready_i) |=> (live_q == $past(live_q) - 1'b1));
  // R4: after a call the frame size is the requested size
  a_r4_call_sets_size: assert property (@(posedge clk) disable iff (!rst_n)
    hist_push_o |=> (size_q == $past(cmd_size_i)));
  // R5: after a return the frame size is the saved caller size
  a_r5_ret_restores_size: assert property (@(posedge clk) disable iff (!rst_n)
    hist_pop_o |=> (size_q == $past(hist_top_i)));
  // R10: spill and fill requests never overlap
  a_r10_no_dual_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_valid_o && fill_valid_o));
  // R10: no acknowledge while transfer traffic is requested
  a_r10_ack_alone: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready_o |-> !(spill_valid_o || fill_valid_o));
  // R8: a refused command changes no frame state
  a_r8_err_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready_o && cmd_err_o) |=> ($stable(base_q) && $stable(size_q)));
endmodule

// File: rtl/frame_renamer.sv
module frame_renamer #(
  parameter int unsigned STATIC = frren_pkg::DEF_STATIC,
  parameter int unsigned POOL   = frren_pkg::DEF_POOL,
  parameter int unsigned HIST   = frren_pkg::DEF_HIST,
  localparam int unsigned LREG_W = $clog2(STATIC + POOL),
  localparam int unsigned SIZE_W = $clog2(POOL + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LREG_W-1:0] lk_lreg_i,
  output logic [LREG_W-1:0] lk_preg_o,
  output logic              lk_oob_o,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic              cmd_call_i,
  input  logic [SIZE_W-1:0] cmd_size_i,
  output logic              cmd_err_o,
  output logic              spill_valid_o,
  input  logic              spill_ready_i,
  output logic [LREG_W-1:0] spill_preg_o,
  output logic              fill_valid_o,
  input  logic              fill_ready_i,
  output logic [LREG_W-1:0] fill_preg_o
);
  localparam int unsigned PTR_W = $clog2(POOL);

  logic [PTR_W-1:0]  base;
  logic [SIZE_W-1:0] size;
  logic [SIZE_W-1:0] hist_top, hist_data;
  logic              hist_full, hist_empty, hist_push, hist_pop;

  frren_ctrl #(
    .STATIC(STATIC), .POOL(POOL), .LREG_W(LREG_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid_i  (cmd_valid_i),
    .cmd_call_i   (cmd_call_i),
    .cmd_size_i   (cmd_size_i),
    .cmd_ready_o  (cmd_ready_o),
    .cmd_err_o    (cmd_err_o),
    .spill_valid_o(spill_valid_o),
    .spill_ready_i(spill_ready_i),
    .spill_preg_o (spill_preg_o),
    .fill_valid_o (fill_valid_o),
    .fill_ready_i (fill_ready_i),
    .fill_preg_o  (fill_preg_o),
    .hist_top_i   (hist_top),
    .hist_full_i  (hist_full),
    .hist_empty_i (hist_empty),
    .hist_push_o  (hist_push),
    .hist_pop_o   (hist_pop),
    .hist_data_o  (hist_data),
    .base_o       (base),
    .size_o       (size)
  );

  frren_hist #(.DEPTH(HIST), .W(SIZE_W)) u_hist (
    .clk    (clk),
    .rst_n  (rst_n),
    .push_i (hist_push),
    .pop_i  (hist_pop),
    .data_i (hist_data),
    .top_o  (hist_top),
    .full_o (hist_full),
    .empty_o(hist_empty)
  );

  frren_map #(
    .STATIC(STATIC), .POOL(POOL), .LREG_W(LREG_W), .PTR_W(PTR_W), .SIZE_W(SIZE_W)
  ) u_map (
    .lreg_i(lk_lreg_i),
    .base_i(base),
    .size_i(size),
    .preg_o(lk_preg_o),
    .oob_o (lk_oob_o)
  );

  // R1: static numbers pass through untouched
  a_r1_static_identity: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lk_lreg_i) < STATIC) |-> (lk_preg_o == lk_lreg_i && !lk_oob_o));
  // R2: stacked numbers always land inside the pool
  a_r2_stacked_in_pool: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(lk_lreg_i) >= STATIC) |-> (32'(lk_preg_o) >= STATIC));
endmodule

// File: tb/frame_renamer_test.sv
module frame_renamer_test;
  localparam int CLK_PERIOD = 10;
  localparam int POOL = 96;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] lk_lreg = '0;
  logic [6:0] lk_preg;
  logic       lk_oob;
  logic       cmd_valid = 1'b0, cmd_call = 1'b0;
  logic [6:0] cmd_size = '0;
  logic       cmd_ready, cmd_err;
  logic       spill_valid, fill_valid;
  logic       spill_ready = 1'b1, fill_ready = 1'b1;
  logic [6:0] spill_preg, fill_preg;

  int nchecks = 0, nerr = 0, cyc = 0;
  bit stall = 0;
  int exp_q[$];
  int m_base, m_cur, m_live;
  int m_hist[$];

  frame_renamer uut (
    .clk(clk), .rst_n(rst_n),
    .lk_lreg_i(lk_lreg), .lk_preg_o(lk_preg), .lk_oob_o(lk_oob),
    .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready), .cmd_call_i(cmd_call),
    .cmd_size_i(cmd_size), .cmd_err_o(cmd_err),
    .spill_valid_o(spill_valid), .spill_ready_i(spill_ready), .spill_preg_o(spill_preg),
    .fill_valid_o(fill_valid), .fill_ready_i(fill_ready), .fill_preg_o(fill_preg)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    nchecks++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  endtask

  // transfer engine ready, optionally stalled on alternate cycles
  always @(negedge clk) begin
    cyc <= cyc + 1;
    spill_ready <= stall ? cyc[0] : 1'b1;
    fill_ready  <= stall ? ~cyc[0] : 1'b1;
  end

  // monitor: pop and compare each transfer that completes at the next edge
  always begin
    @(negedge clk);
    #1;
    if (rst_n && spill_valid && fill_valid) chk("R10 dual request", 1, 0);
    if (rst_n && spill_valid && spill_ready) begin
      if (exp_q.size() == 0) chk("R6 unexpected spill", spill_preg, -1);
      else chk("R6 spill index", 1000 + spill_preg, exp_q.pop_front());
    end
    if (rst_n && fill_valid && fill_ready) begin
      if (exp_q.size() == 0) chk("R7 unexpected fill", fill_preg, -1);
      else chk("R7 fill index", 2000 + fill_preg, exp_q.pop_front());
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    m_base = 0; m_cur = 0; m_live = 0;
    m_hist.delete(); exp_q.delete();
  endtask

  task automatic look(input int l);
    int ep; bit eo;
    string tag;
    @(negedge clk);
    lk_lreg = 7'(l);
    #1;
    if (l < 32) begin ep = l; eo = 0; tag = "R1"; end
    else begin
      eo = (l - 32) >= m_cur;
      ep = 32 + (m_base + l - 32) % POOL;
      tag = eo ? "R3" : "R2";
    end
    chk({tag, " oob"}, lk_oob, eo);
    if (!eo) chk({tag, " preg"}, lk_preg, ep);
  endtask

  // driver: predicts transfers into the scoreboard, then issues the command
  task automatic do_cmd(input bit call, input int size, input string tag);
    bit exp_err, released;
    int ob, oc, s, n;
    exp_err = 0; released = 0; ob = m_base; oc = m_cur;
    if (call) begin
      if (m_hist.size() == 16 || size > POOL) exp_err = 1;
      else begin
        while (m_live + size > POOL) begin
          exp_q.push_back(1000 + 32 + (m_base + m_cur + POOL - m_live) % POOL);
          m_live--;
        end
        m_hist.push_back(m_cur);
        m_base = (m_base + m_cur) % POOL; m_cur = size; m_live += size;
      end
    end else begin
      if (m_hist.size() == 0) exp_err = 1;
      else begin
        s = m_hist.pop_back();
        if (m_live - m_cur < s) begin
          released = 1;
          m_live -= m_cur; m_cur = 0;
          while (m_live < s) begin
            exp_q.push_back(2000 + 32 + (m_base + 2 * POOL - m_live - 1) % POOL);
            m_live++;
          end
        end
        m_live -= m_cur;
        m_base = (m_base + POOL - s) % POOL; m_cur = s;
      end
    end
    @(negedge clk);
    lk_lreg = 7'd32; cmd_call = call; cmd_size = 7'(size); cmd_valid = 1'b1;
    n = 0;
    forever begin
      #1;
      if (cmd_ready) break;
      @(negedge clk);
      n++;
      if (n > 5000) begin chk({tag, " ack timeout"}, 0, 1); break; end
    end
    chk({tag, " err flag"}, cmd_err, exp_err);
    chk("R10 no transfer at ack", spill_valid | fill_valid, 0);
    // R11: old frame still visible in the acknowledge cycle
    chk("R11 ack-cycle oob", lk_oob, (released || oc == 0) ? 1 : 0);
    if (!released && oc != 0) chk("R11 ack-cycle preg", lk_preg, 32 + ob);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk({tag, " pending transfers"}, exp_q.size(), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk("watchdog", 0, 1);
    finish_run();
  end

  initial begin
    do_reset();
    // reset state
    look(5); look(31); look(32);
    chk("R2 reset no spill", spill_valid, 0);
    chk("R2 reset no fill", fill_valid, 0);
    // nested calls without overflow
    do_cmd(1, 10, "R4"); look(32); look(41); look(42); look(0);
    do_cmd(1, 20, "R4"); look(32); look(51); look(52);
    do_cmd(1, 50, "R4"); look(32); look(81); look(82);
    // overflow: spills, wrap-around mapping
    do_cmd(1, 40, "R6"); look(32); look(52); look(71); look(72);
    // returns: resident, then with fills
    do_cmd(0, 0, "R5"); look(32); look(81); look(82);
    do_cmd(0, 0, "R7"); look(32); look(51); look(52);
    do_cmd(0, 0, "R7"); look(32); look(41);
    do_cmd(0, 0, "R5"); look(32);
    // refused commands
    do_cmd(0, 0, "R9"); look(32); look(40);
    do_cmd(1, 97, "R8"); look(32);
    // full-pool frames with stalled transfer engine
    do_cmd(1, 96, "R4"); look(32); look(127);
    stall = 1;
    do_cmd(1, 96, "R6"); look(32); look(127);
    do_cmd(0, 0, "R7"); look(32); look(127);
    stall = 0;
    // history depth
    do_reset();
    for (int i = 0; i < 16; i++) do_cmd(1, 1, "R4");
    look(32); look(33);
    do_cmd(1, 1, "R8"); look(32); look(33);
    do_cmd(0, 0, "R5"); look(32);
    finish_run();
  end
endmodule